// File: doc/BRIEF.md
# Distributed Bus Arbiter Node

This block decides which of several processor nodes, or an attached host, drives a shared external bus. Every node on the bus carries an identical copy. Each copy watches the full set of processor request lines, the shared lock line, the transfer-busy line and the host request, and is told its own node number. Because all copies start from the same reset state and apply the same rule to the same inputs on the same clock edge, they always agree on the owner. No central arbiter is needed. Each copy raises only its own node's grant.

Among processors the winner is chosen either by fixed priority, where the lowest node number wins, or by rotating priority, where the search starts at the node just after the most recent owner. An owner keeps the bus for as long as it keeps requesting. A lock line lets the owner hold the bus through an indivisible read-modify-write sequence. The host has precedence over all processors. It is granted only when no transfer is in flight and no lock is held. Every change of owner passes through exactly one idle cycle in which nobody holds a grant.

Top module: `busarb_node`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `node_grant`, `host_grant` and `master_valid` are all 0.
- R2: From the idle state, with `host_req` low and at least one bit of `bus_req` set, a processor owns the bus after the next clock edge. With `rotate_en` = 0, the owner is the set bit with the lowest index.
- R3: With `rotate_en` = 1, the new owner is the first set bit of `bus_req` found by searching upward and wrapping, starting at the index one above the previous owner. After reset, the previous owner counts as node NODES-1.
- R4: An owner whose `bus_req` bit stays set keeps the bus, even when lower-numbered nodes request. This holds unless the host takes the bus under R7.
- R5: When the owner's `bus_req` bit drops while `bus_lock` is low, the next cycle has no owner and no host grant. Arbitration resumes the cycle after that.
- R6: While `bus_lock` is high, the current owner keeps the bus whatever `bus_req`, `host_req` and `xfer_busy` do.
- R7: The host wins over processors. It is granted only after a cycle in which `host_req` is high and both `xfer_busy` and `bus_lock` are low. A processor owner yields through one idle cycle. While `host_grant` is high, `master_valid` and `node_grant` are 0.
- R8: `node_grant` is high exactly when a processor owns the bus and `master_id` equals `node_id`. Copies with different `node_id` values never grant at the same time.
- R9: When `host_req` drops during a host grant, one idle cycle follows. Processor arbitration then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | IDW | Number of the node this copy serves |
| bus_req | input | NODES | One request line per processor node |
| rotate_en | input | 1 | 1 = rotating priority, 0 = fixed priority |
| bus_lock | input | 1 | Owner holds the bus across an atomic sequence |
| xfer_busy | input | 1 | A processor transfer is still in progress |
| host_req | input | 1 | Host bus request |
| node_grant | output | 1 | This node owns the bus |
| host_grant | output | 1 | Host owns the bus |
| master_valid | output | 1 | Some processor owns the bus |
| master_id | output | IDW | Number of the processor that owns or last owned the bus |

## Verification
The bench uses the default of six processor nodes. It builds two copies with node numbers 2 and 0 on the same lines, so the grant of each copy, and the rule that the two never grant together, can be observed against one shared owner. Six nodes are enough to show the rotating search wrap from node 5 back to node 0, and to show a fixed-priority choice that differs from the rotating one. A behavioural model in the bench predicts the owner on every cycle. Directed checks cover the handover gap, the lock hold and the host waiting on the busy line.

// File: rtl/busarb_node.sv
module busarb_node #(
  parameter int NODES = 6,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDW-1:0]   node_id,
  input  logic [NODES-1:0] bus_req,
  input  logic             rotate_en,
  input  logic             bus_lock,
  input  logic             xfer_busy,
  input  logic             host_req,
  output logic             node_grant,
  output logic             host_grant,
  output logic             master_valid,
  output logic [IDW-1:0]   master_id
);
  typedef enum logic [1:0] {S_IDLE, S_PROC, S_HOST} st_t;

  st_t           st_q;
  logic [IDW-1:0] owner_q;
  logic [IDW-1:0] winner;
  logic           host_ok;

  function automatic logic [IDW-1:0] pick(input logic [NODES-1:0] r,
                                          input logic rot,
                                          input logic [IDW-1:0] prev);
    logic [IDW-1:0] w;
    logic           found;
    int             idx;
    w     = '0;
    found = 1'b0;
    for (int k = 0; k < NODES; k++) begin
      idx = rot ? (int'(prev) + 1 + k) % NODES : k;
      if (!found && r[idx]) begin
        w     = IDW'(idx);
        found = 1'b1;
      end
    end
    return w;
  endfunction

  assign winner  = pick(bus_req, rotate_en, owner_q);
  assign host_ok = host_req && !xfer_busy && !bus_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      owner_q <= IDW'(NODES - 1);
    end else begin
      case (st_q)
        S_IDLE: begin
          if (host_req) begin
            if (host_ok) st_q <= S_HOST;
          end else if (|bus_req) begin
            st_q    <= S_PROC;
            owner_q <= winner;
          end
        end
        S_PROC: begin
          if (!bus_lock && (host_ok || !bus_req[owner_q])) st_q <= S_IDLE;
        end
        S_HOST: begin
          if (!host_req) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign master_valid = (st_q == S_PROC);
  assign host_grant   = (st_q == S_HOST);
  assign master_id    = owner_q;
  assign node_grant   = master_valid && (owner_q == node_id);
endmodule

// File: rtl/busarb_node_chk.sv
module busarb_node_chk #(
  parameter int NODES = 6,
  localparam int IDW = (NODES > 1) ? $clog2(NODES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDW-1:0]   node_id,
  input logic [NODES-1:0] bus_req,
  input logic             bus_lock,
  input logic             xfer_busy,
  input logic             host_req,
  input logic             node_grant,
  input logic             host_grant,
  input logic             master_valid,
  input logic [IDW-1:0]   master_id
);
  assert_host_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> (!master_valid && !node_grant));

  assert_host_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_grant) |-> $past(host_req && !xfer_busy && !bus_lock));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_valid && bus_lock) |=> (master_valid && $stable(master_id)));

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_valid && bus_req[master_id] && !(host_req && !xfer_busy)) |=>
      (master_valid && $stable(master_id)));

  assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_valid && !bus_lock && !bus_req[master_id]) |=> (!master_valid && !host_grant));

  assert_own_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    node_grant |-> (master_valid && master_id == node_id));

  assert_host_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant && !host_req) |=> (!host_grant && !master_valid));
endmodule

bind busarb_node busarb_node_chk #(.NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .bus_req(bus_req),
  .bus_lock(bus_lock), .xfer_busy(xfer_busy), .host_req(host_req),
  .node_grant(node_grant), .host_grant(host_grant),
  .master_valid(master_valid), .master_id(master_id)
);

// File: tb/busarb_node_bench.sv
module busarb_node_bench;
  localparam int NODES = 6;
  localparam int IDW = $clog2(NODES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NODES-1:0] bus_req = '0;
  logic rotate_en = 1'b0, bus_lock = 1'b0, xfer_busy = 1'b0, host_req = 1'b0;
  logic g_a, g_b, hg_a, hg_b, mv_a, mv_b;
  logic [IDW-1:0] id_a, id_b;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  busarb_node #(.NODES(NODES)) u_busarb_node (
    .clk(clk), .rst_n(rst_n), .node_id(IDW'(2)), .bus_req(bus_req),
    .rotate_en(rotate_en), .bus_lock(bus_lock), .xfer_busy(xfer_busy),
    .host_req(host_req), .node_grant(g_a), .host_grant(hg_a),
    .master_valid(mv_a), .master_id(id_a));

  busarb_node #(.NODES(NODES)) u_busarb_node_peer (
    .clk(clk), .rst_n(rst_n), .node_id(IDW'(0)), .bus_req(bus_req),
    .rotate_en(rotate_en), .bus_lock(bus_lock), .xfer_busy(xfer_busy),
    .host_req(host_req), .node_grant(g_b), .host_grant(hg_b),
    .master_valid(mv_b), .master_id(id_b));

  // behavioural reference: owner = -1 idle, -2 host, else node number
  int owner = -1;
  int prev = NODES - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      owner = -1;
      prev  = NODES - 1;
    end else if (owner == -1) begin
      if (host_req) begin
        if (!xfer_busy && !bus_lock) owner = -2;
      end else begin
        for (int k = 0; k < NODES; k++) begin
          int cand;
          cand = rotate_en ? (prev + 1 + k) % NODES : k;
          if (owner == -1 && bus_req[cand]) owner = cand;
        end
        if (owner >= 0) prev = owner;
      end
    end else if (owner == -2) begin
      if (!host_req) owner = -1;
    end else begin
      if (!bus_lock && ((host_req && !xfer_busy) || !bus_req[owner])) owner = -1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 owner valid", int'(mv_a), int'(owner >= 0));
      chk("R7 host grant", int'(hg_a), int'(owner == -2));
      chk("R8 grant node2", int'(g_a), int'(owner == 2));
      chk("R8 grant node0", int'(g_b), int'(owner == 0));
      chk("R8 copies agree", int'({mv_b, hg_b, id_b}), int'({mv_a, hg_a, id_a}));
      if (owner >= 0) chk("R3 owner id", int'(id_a), owner);
      chk("R8 never both", int'(g_a && g_b), 0);
    end
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    step(); step();
    chk("R1 reset grant", int'(g_a), 0);
    chk("R1 reset host", int'(hg_a), 0);
    chk("R1 reset valid", int'(mv_a), 0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", int'(mv_a | hg_a | g_a), 0);

    bus_req = 6'b001100; step();
    chk("R2 fixed owner", int'(id_a), 2);
    chk("R2 grant node2", int'(g_a), 1);

    bus_req = 6'b001101; step();
    chk("R4 keeps bus", int'(id_a), 2);

    bus_req = 6'b001001; step();
    chk("R5 gap", int'(mv_a | hg_a), 0);
    step();
    chk("R2 lowest wins", int'(id_a), 0);
    chk("R8 peer grant", int'(g_b), 1);

    rotate_en = 1'b1; bus_req = 6'b101000; step();
    chk("R5 gap rot", int'(mv_a), 0);
    step();
    chk("R3 after 0", int'(id_a), 3);

    bus_req = 6'b100001; step(); step();
    chk("R3 after 3", int'(id_a), 5);

    bus_lock = 1'b1; bus_req = 6'b000001; host_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6 lock hold", int'(id_a), 5);
      chk("R6 lock no host", int'(hg_a), 0);
    end

    bus_lock = 1'b0; bus_req = 6'b100001; xfer_busy = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R7 host waits busy", int'(hg_a), 0);
      chk("R7 owner stays", int'(mv_a), 1);
    end

    xfer_busy = 1'b0; step();
    chk("R7 gap before host", int'(mv_a | hg_a), 0);
    step();
    chk("R7 host granted", int'(hg_a), 1);
    chk("R7 no proc grant", int'(mv_a | g_a | g_b), 0);
    step();
    chk("R7 host holds", int'(hg_a), 1);

    host_req = 1'b0; step();
    chk("R9 gap after host", int'(mv_a | hg_a), 0);
    step();
    chk("R9 wrap to 0", int'(id_a), 0);
    chk("R9 peer grant", int'(g_b), 1);

    bus_req = 6'b000000; step(); step();
    chk("R5 idle", int'(mv_a), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule